// File: doc/BRIEF.md
# Compact 32-bit Load/Store Processor Core

This block is a small multi-cycle processor for a 32-bit load/store integer instruction set. It fetches instruction words from an external synchronous instruction ROM and reads and writes words in an external synchronous data RAM. It holds a 32-entry register file in which register 0 always reads as zero. A one-cycle `start` pulse resets the program counter and the register file and begins execution. The core then runs one instruction at a time through four fixed states: fetch, decode, execute and writeback.

A program ends when the program counter is zero after an instruction completes. The core has no exception path, so an undecodable opcode or function code simply forces the program counter to zero and so stops the run. At the end of a run the core raises `done` and shows the number of instructions it retired. Both memories are indexed by byte address bits [7:2] only. There are no delay slots, and there is no multiplier, so the HI and LO values that the move instructions read are always zero.

Top module: `minicore_top`

## Requirements
- R1: After reset `busy` and `done` are 0 and `retired` is 0. Each accepted `start` clears every register except register 29, which is loaded with 0x7FFFEFFC, and begins fetching at byte address 0x00400000 (ROM word 0).
- R2: Each instruction takes exactly 4 clock cycles, and `retired` goes up by one for each instruction, including the one that halts. A program of N instructions raises `done` 4N cycles after the clock edge that accepts `start`, and `busy` is 1 during the run.
- R3: A write to register 0 has no effect, so register 0 always reads as zero.
- R4: Register-register operations use opcode 0 with the function code in bits [5:0], rs in [25:21], rt in [20:16], rd in [15:11] and shamt in [10:6]. The function codes are ADDU 33, SUBU 35, AND 36, OR 37, XOR 38, SLT 42 (signed), SLTU 43 (unsigned), SLL 0 and SRL 2 (by shamt), and SLLV 4 and SRLV 6 (by rs[4:0]). Right shifts fill with zeros.
- R5: Immediate operations take the 16-bit immediate in bits [15:0]. ADDIU (9) and SLTI (10) sign-extend it. SLTIU (11) sign-extends it and then compares unsigned. ANDI (12), ORI (13) and XORI (14) zero-extend it. LUI (15) places it in bits [31:16] with zeros below.
- R6: LW (35) and SW (43) address the word at bits [7:2] of rs plus the sign-extended immediate. All other address bits are ignored.
- R7: BEQ (4), BNE (5) and BGEZ (1, which tests rs as signed and is at least zero) branch, when taken, to the branch's own address plus four times the sign-extended immediate. When not taken, execution continues at the next word.
- R8: J (2) and JAL (3) jump to bits [25:0] shifted left by 2, with no upper bits merged in. JAL writes the address of the next word to register 31. JR (function 8) jumps to rs.
- R9: MFHI (function 16) and MFLO (function 18) write zero to rd.
- R10: An unknown opcode or an unknown function code under opcode 0 sets the program counter to zero, which halts the run. The halting instruction is counted.
- R11: When the program counter is zero after writeback, `done` rises and `busy` falls. `done` and `retired` then hold until the next `start`, which clears `done`.
- R12: `start` has no effect while a program is running.
- R13: The reference exchange-sort program leaves -17, -9, 0, 3, 5, 11, 22, 38 in data words 0 to 7 and retires exactly 611 instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| imem_addr | output | IDX_W | Instruction ROM word index (PC bits [7:2]) |
| imem_rdata | input | 32 | Instruction word, one cycle after the address |
| dmem_addr | output | IDX_W | Data RAM word index, valid in the execute state |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per SW |
| dmem_rdata | input | 32 | Load data, one cycle after the address |
| busy | output | 1 | A program is running |
| done | output | 1 | The last run has halted |
| retired | output | CNT_W | Instructions retired in the current or last run |

## Verification
Results are due on a fixed schedule. `busy` rises one edge after the `start` edge, and `done` follows 4N edges after that edge, where N is the bench's hand count of the instructions on the taken path. The bench counts cycles from the start pulse to `done` and compares the total with 4N. It compares `retired` with N. All register results are moved to data words by stores, and the bench reads those words only after `done`. All sampling happens on the falling clock edge.

// File: rtl/minicore_pkg.sv
package minicore_pkg;
  localparam int XLEN = 32;
  localparam int NUM_REGS = 32;
  localparam int REG_AW = $clog2(NUM_REGS);

  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_BGEZ    = 6'd1;
  localparam logic [5:0] OP_J       = 6'd2;
  localparam logic [5:0] OP_JAL     = 6'd3;
  localparam logic [5:0] OP_BEQ     = 6'd4;
  localparam logic [5:0] OP_BNE     = 6'd5;
  localparam logic [5:0] OP_ADDIU   = 6'd9;
  localparam logic [5:0] OP_SLTI    = 6'd10;
  localparam logic [5:0] OP_SLTIU   = 6'd11;
  localparam logic [5:0] OP_ANDI    = 6'd12;
  localparam logic [5:0] OP_ORI     = 6'd13;
  localparam logic [5:0] OP_XORI    = 6'd14;
  localparam logic [5:0] OP_LUI     = 6'd15;
  localparam logic [5:0] OP_LW      = 6'd35;
  localparam logic [5:0] OP_SW      = 6'd43;

  localparam logic [5:0] FN_SLL  = 6'd0;
  localparam logic [5:0] FN_SRL  = 6'd2;
  localparam logic [5:0] FN_SLLV = 6'd4;
  localparam logic [5:0] FN_SRLV = 6'd6;
  localparam logic [5:0] FN_JR   = 6'd8;
  localparam logic [5:0] FN_MFHI = 6'd16;
  localparam logic [5:0] FN_MFLO = 6'd18;
  localparam logic [5:0] FN_ADDU = 6'd33;
  localparam logic [5:0] FN_SUBU = 6'd35;
  localparam logic [5:0] FN_AND  = 6'd36;
  localparam logic [5:0] FN_OR   = 6'd37;
  localparam logic [5:0] FN_XOR  = 6'd38;
  localparam logic [5:0] FN_SLT  = 6'd42;
  localparam logic [5:0] FN_SLTU = 6'd43;

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_DECODE, ST_EXEC, ST_WB} core_state_t;
endpackage

// File: rtl/minicore_regfile.sv
module minicore_regfile #(
  parameter int NREG = 32,
  parameter int DW = 32,
  parameter int SP_IDX = 29,
  parameter logic [31:0] SP_INIT = 32'h7FFF_EFFC,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [DW-1:0] ra_val,
  output logic [DW-1:0] rb_val,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst || init) begin
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == SP_IDX) ? DW'(SP_INIT) : '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign ra_val = regs[ra];
  assign rb_val = regs[rb];

  AST_ZERO_REG_KEPT: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0) |=> (regs[0] == '0)) else $error("register 0 changed"); // R3
endmodule

// File: rtl/minicore_exec.sv
module minicore_exec
  import minicore_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [31:0]       ir,
  input  logic [31:0]       rs_val,
  input  logic [31:0]       rt_val,
  input  logic [31:0]       pc_seq,
  output logic [31:0]       result,
  output logic [31:0]       next_pc,
  output logic [IDX_W-1:0]  mem_idx,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_idx,
  output logic              is_load,
  output logic              is_store
);
  logic [5:0]  op, fn;
  logic [4:0]  f_rs, f_rt, f_rd, f_sh;
  logic [31:0] simm, zimm, br_tgt;

  assign op   = ir[31:26];
  assign f_rs = ir[25:21];
  assign f_rt = ir[20:16];
  assign f_rd = ir[15:11];
  assign f_sh = ir[10:6];
  assign fn   = ir[5:0];
  assign simm = {{16{ir[15]}}, ir[15:0]};
  assign zimm = {16'h0000, ir[15:0]};
  assign br_tgt = pc_seq - 32'd4 + {simm[29:0], 2'b00};
  assign mem_idx = IDX_W'((rs_val[IDX_W+1:0] + simm[IDX_W+1:0]) >> 2);

  always_comb begin
    result   = '0;
    next_pc  = pc_seq;
    wr_en    = 1'b0;
    wr_idx   = f_rt;
    is_load  = 1'b0;
    is_store = 1'b0;
    case (op)
      OP_SPECIAL: begin
        wr_en  = 1'b1;
        wr_idx = f_rd;
        case (fn)
          FN_ADDU: result = rs_val + rt_val;
          FN_SUBU: result = rs_val - rt_val;
          FN_AND:  result = rs_val & rt_val;
          FN_OR:   result = rs_val | rt_val;
          FN_XOR:  result = rs_val ^ rt_val;
          FN_SLT:  result = {31'd0, $signed(rs_val) < $signed(rt_val)};
          FN_SLTU: result = {31'd0, rs_val < rt_val};
          FN_SLL:  result = rt_val << f_sh;
          FN_SRL:  result = rt_val >> f_sh;
          FN_SLLV: result = rt_val << rs_val[4:0];
          FN_SRLV: result = rt_val >> rs_val[4:0];
          FN_MFHI, FN_MFLO: result = '0;
          FN_JR: begin
            wr_en   = 1'b0;
            next_pc = rs_val;
          end
          default: begin
            wr_en   = 1'b0;
            next_pc = '0;
          end
        endcase
      end
      OP_J:   next_pc = {4'b0000, ir[25:0], 2'b00};
      OP_JAL: begin
        next_pc = {4'b0000, ir[25:0], 2'b00};
        wr_en   = 1'b1;
        wr_idx  = REG_AW'(31);
        result  = pc_seq;
      end
      OP_BEQ:  if (rs_val == rt_val) next_pc = br_tgt;
      OP_BNE:  if (rs_val != rt_val) next_pc = br_tgt;
      OP_BGEZ: if (!rs_val[31]) next_pc = br_tgt;
      OP_ADDIU: begin wr_en = 1'b1; result = rs_val + simm; end
      OP_SLTI:  begin wr_en = 1'b1; result = {31'd0, $signed(rs_val) < $signed(simm)}; end
      OP_SLTIU: begin wr_en = 1'b1; result = {31'd0, rs_val < simm}; end
      OP_ANDI:  begin wr_en = 1'b1; result = rs_val & zimm; end
      OP_ORI:   begin wr_en = 1'b1; result = rs_val | zimm; end
      OP_XORI:  begin wr_en = 1'b1; result = rs_val ^ zimm; end
      OP_LUI:   begin wr_en = 1'b1; result = {ir[15:0], 16'h0000}; end
      OP_LW:    begin wr_en = 1'b1; is_load = 1'b1; end
      OP_SW:    is_store = 1'b1;
      default:  next_pc = '0;
    endcase
  end
endmodule

// File: rtl/minicore_top.sv
module minicore_top
  import minicore_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CNT_W = 32,
  parameter logic [31:0] BOOT_PC = 32'h0040_0000,
  parameter logic [31:0] STACK_INIT = 32'h7FFF_EFFC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [IDX_W-1:0] imem_addr,
  input  logic [31:0]      imem_rdata,
  output logic [IDX_W-1:0] dmem_addr,
  output logic [31:0]      dmem_wdata,
  output logic             dmem_we,
  input  logic [31:0]      dmem_rdata,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] retired
);
  core_state_t       state;
  logic [31:0]       pc, ir, res_q, npc_q;
  logic              wen_q, load_q;
  logic [REG_AW-1:0] widx_q;

  logic [31:0]       rs_val, rt_val, ex_result, ex_next_pc;
  logic [IDX_W-1:0]  ex_mem_idx;
  logic              ex_wr_en, ex_load, ex_store, launch;
  logic [REG_AW-1:0] ex_wr_idx;

  assign launch = (state == ST_IDLE) && start;

  minicore_regfile #(
    .NREG(NUM_REGS), .DW(XLEN), .SP_IDX(29), .SP_INIT(STACK_INIT)
  ) u_rf (
    .clk(clk), .rst(rst), .init(launch),
    .ra(ir[25:21]), .rb(ir[20:16]), .ra_val(rs_val), .rb_val(rt_val),
    .we((state == ST_WB) && wen_q), .wa(widx_q),
    .wd(load_q ? dmem_rdata : res_q)
  );

  minicore_exec #(.IDX_W(IDX_W)) u_ex (
    .ir(ir), .rs_val(rs_val), .rt_val(rt_val), .pc_seq(pc),
    .result(ex_result), .next_pc(ex_next_pc), .mem_idx(ex_mem_idx),
    .wr_en(ex_wr_en), .wr_idx(ex_wr_idx), .is_load(ex_load), .is_store(ex_store)
  );

  assign imem_addr  = pc[IDX_W+1:2];
  assign dmem_addr  = ex_mem_idx;
  assign dmem_wdata = rt_val;
  assign dmem_we    = (state == ST_EXEC) && ex_store;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pc      <= BOOT_PC;
      ir      <= '0;
      res_q   <= '0;
      npc_q   <= '0;
      wen_q   <= 1'b0;
      load_q  <= 1'b0;
      widx_q  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      retired <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_FETCH;
          pc      <= BOOT_PC;
          retired <= '0;
          busy    <= 1'b1;
          done    <= 1'b0;
        end
        ST_FETCH: state <= ST_DECODE;
        ST_DECODE: begin
          ir    <= imem_rdata;
          pc    <= pc + 32'd4;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          res_q  <= ex_result;
          npc_q  <= ex_next_pc;
          wen_q  <= ex_wr_en;
          widx_q <= ex_wr_idx;
          load_q <= ex_load;
          state  <= ST_WB;
        end
        ST_WB: begin
          pc      <= npc_q;
          retired <= retired + CNT_W'(1);
          if (npc_q == '0) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            state <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB) |=> (retired == $past(retired) + CNT_W'(1))) else $error("count step"); // R2
  AST_RETIRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_WB && !launch) |=> $stable(retired)) else $error("count moved"); // R2
  AST_HALT_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB && npc_q == '0) |=> (done && !busy)) else $error("no halt"); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("done while busy"); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && state != ST_WB) |=> busy) else $error("start disturbed run"); // R12
endmodule

// File: tb/sim_minicore_top.sv
module sim_minicore_top;
  localparam logic [31:0] HALT_W = 32'hFC00_0000;
  localparam logic [5:0] O_BGEZ = 1, O_J = 2, O_JAL = 3, O_BEQ = 4, O_BNE = 5, O_ADDIU = 9,
    O_SLTI = 10, O_SLTIU = 11, O_ANDI = 12, O_ORI = 13, O_XORI = 14, O_LUI = 15,
    O_LW = 35, O_SW = 43;
  localparam logic [5:0] F_SLL = 0, F_SRL = 2, F_SLLV = 4, F_SRLV = 6, F_JR = 8,
    F_MFHI = 16, F_MFLO = 18, F_ADDU = 33, F_SUBU = 35, F_AND = 36, F_OR = 37,
    F_XOR = 38, F_SLT = 42, F_SLTU = 43;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [5:0]  imem_addr, dmem_addr;
  logic [31:0] imem_rdata, dmem_wdata, dmem_rdata;
  logic        dmem_we, busy, done;
  logic [31:0] retired;

  logic [31:0] rom [64];
  logic [31:0] ram [64];
  logic        pk_en = 1'b0;
  logic        pk_rom = 1'b0;
  logic [5:0]  pk_idx = '0;
  logic [31:0] pk_val = '0;

  int total = 0;
  int bad = 0;
  int pidx = 0;

  always #5 clk = ~clk;

  minicore_top u0 (
    .clk(clk), .rst(rst), .start(start),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .busy(busy), .done(done), .retired(retired)
  );

  always @(posedge clk) begin
    imem_rdata <= rom[imem_addr];
    dmem_rdata <= ram[dmem_addr];
    if (dmem_we) ram[dmem_addr] <= dmem_wdata;
    if (pk_en) begin
      if (pk_rom) rom[pk_idx] <= pk_val;
      else        ram[pk_idx] <= pk_val;
    end
  end

  function automatic logic [31:0] ri(input logic [5:0] fn, input int rs, input int rt,
                                     input int rd, input int sh);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] ii(input logic [5:0] op, input int rs, input int rt,
                                     input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] jj(input logic [5:0] op, input logic [25:0] tgt);
    return {op, tgt};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic poke(input bit to_rom, input int idx, input logic [31:0] w);
    @(negedge clk);
    pk_en = 1'b1; pk_rom = to_rom; pk_idx = 6'(idx); pk_val = w;
  endtask
  task automatic poke_end();
    @(negedge clk);
    pk_en = 1'b0;
  endtask
  task automatic wipe(input logic [31:0] fill);
    for (int i = 0; i < 64; i++) begin
      poke(1'b1, i, HALT_W);
      poke(1'b0, i, fill);
    end
    pidx = 0;
  endtask
  task automatic emit(input logic [31:0] w);
    poke(1'b1, pidx, w);
    pidx++;
  endtask
  task automatic st(input int r, input int k);
    emit(ii(O_SW, 0, r, 16'(4 * k)));
  endtask

  // Runs the loaded program; N instructions must take 4N cycles (R2)
  task automatic run(input int n_exp, input bit poke_start, input string tag);
    int cyc;
    poke_end();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 1;
    chk({tag, " R2 busy"}, {31'd0, busy}, 32'd1);
    chk({tag, " R11 done cleared"}, {31'd0, done}, 32'd0);
    while (!done && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      start = poke_start && (cyc == 20);
    end
    start = 1'b0;
    chk({tag, " R2 cycles"}, 32'(cyc - 1), 32'(4 * n_exp));
    chk({tag, " R2 retired"}, retired, 32'(n_exp));
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 retired", retired, 32'd0);
  endtask

  task automatic test_alu();
    wipe(32'hDEAD_BEEF);
    emit(ii(O_ADDIU, 0, 1, 16'hFFF9));
    emit(ii(O_ADDIU, 0, 2, 16'd5));
    emit(ri(F_ADDU, 1, 2, 3, 0)); st(3, 0);
    emit(ri(F_SUBU, 2, 1, 3, 0)); st(3, 1);
    emit(ri(F_AND, 1, 2, 3, 0));  st(3, 2);
    emit(ri(F_OR, 1, 2, 3, 0));   st(3, 3);
    emit(ri(F_XOR, 1, 2, 3, 0));  st(3, 4);
    emit(ri(F_SLT, 1, 2, 3, 0));  st(3, 5);
    emit(ri(F_SLTU, 1, 2, 3, 0)); st(3, 6);
    emit(ri(F_SRL, 0, 1, 3, 4));  st(3, 7);
    emit(ri(F_SLL, 0, 2, 3, 3));  st(3, 8);
    emit(ii(O_ADDIU, 0, 4, 16'h0024));
    emit(ri(F_SLLV, 4, 2, 3, 0)); st(3, 9);
    emit(ri(F_SRLV, 4, 1, 3, 0)); st(3, 10);
    emit(ri(F_ADDU, 1, 2, 0, 0)); st(0, 11);
    emit(ri(F_MFHI, 0, 0, 3, 0)); st(3, 12);
    emit(ii(O_ADDIU, 0, 5, 16'd77));
    emit(ri(F_MFLO, 0, 0, 5, 0)); st(5, 13);
    emit(HALT_W);
    run(pidx, 1'b0, "alu");
    chk("R4 addu", ram[0], 32'hFFFF_FFFE);
    chk("R4 subu", ram[1], 32'd12);
    chk("R4 and", ram[2], 32'd1);
    chk("R4 or", ram[3], 32'hFFFF_FFFD);
    chk("R4 xor", ram[4], 32'hFFFF_FFFC);
    chk("R4 slt", ram[5], 32'd1);
    chk("R4 sltu", ram[6], 32'd0);
    chk("R4 srl", ram[7], 32'h0FFF_FFFF);
    chk("R4 sll", ram[8], 32'd40);
    chk("R4 sllv", ram[9], 32'd80);
    chk("R4 srlv", ram[10], 32'h0FFF_FFFF);
    chk("R3 reg0", ram[11], 32'd0);
    chk("R9 mfhi", ram[12], 32'd0);
    chk("R9 mflo", ram[13], 32'd0);
  endtask

  task automatic test_flow();
    wipe(32'hDEAD_BEEF);
    emit(ii(O_ADDIU, 0, 1, 16'hFFFF));   // 0
    emit(ii(O_BGEZ, 1, 1, 16'd3));       // 1 not taken
    emit(ii(O_ADDIU, 0, 2, 16'd1));      // 2
    emit(ii(O_BEQ, 0, 0, 16'd2));        // 3 -> 5
    emit(ii(O_ADDIU, 0, 2, 16'd99));     // 4
    emit(ii(O_BNE, 1, 0, 16'd2));        // 5 -> 7
    emit(ii(O_ADDIU, 0, 2, 16'd98));     // 6
    st(2, 0);                            // 7
    emit(ii(O_BGEZ, 0, 1, 16'd2));       // 8 -> 10
    st(1, 1);                            // 9
    emit(jj(O_JAL, 26'h10000E));         // 10 -> 14
    st(31, 2);                           // 11
    emit(jj(O_J, 26'h100010));           // 12 -> 16
    emit(HALT_W);                        // 13
    emit(ii(O_ADDIU, 0, 3, 16'd7));      // 14
    emit(ri(F_JR, 31, 0, 0, 0));         // 15 -> 11
    st(3, 3);                            // 16
    emit(ii(O_ADDIU, 4, 4, 16'd1));      // 17
    emit(ii(O_SLTI, 4, 5, 16'd3));       // 18
    emit(ii(O_BNE, 5, 0, 16'hFFFE));     // 19 -> 17
    st(4, 4);                            // 20
    emit(HALT_W);                        // 21
    run(24, 1'b1, "flow R12");
    chk("R7 fallthrough and skips", ram[0], 32'd1);
    chk("R7 bgez taken", ram[1], 32'hDEAD_BEEF);
    chk("R8 jal link", ram[2], 32'h0040_002C);
    chk("R8 jr return", ram[3], 32'd7);
    chk("R7 backward loop", ram[4], 32'd3);
    repeat (5) @(negedge clk);
    chk("R11 done held", {31'd0, done}, 32'd1);
    chk("R11 busy low", {31'd0, busy}, 32'd0);
    chk("R11 retired held", retired, 32'd24);
  endtask

  task automatic test_imm();
    wipe(32'hDEAD_BEEF);
    emit(ii(O_ADDIU, 0, 1, 16'h8001));  st(1, 0);
    emit(ii(O_ANDI, 1, 2, 16'hF0F0));   st(2, 1);
    emit(ii(O_ORI, 0, 2, 16'h8001));    st(2, 2);
    emit(ii(O_XORI, 1, 2, 16'hFFFF));   st(2, 3);
    emit(ii(O_LUI, 0, 2, 16'h8765));    st(2, 4);
    emit(ii(O_SLTI, 1, 2, 16'h0000));   st(2, 5);
    emit(ii(O_SLTIU, 0, 2, 16'hFFFF));  st(2, 6);
    emit(ii(O_SLTIU, 1, 2, 16'h0001));  st(2, 7);
    st(4, 8);
    st(29, 9);
    emit(HALT_W);
    run(pidx, 1'b0, "imm");
    chk("R5 addiu sign", ram[0], 32'hFFFF_8001);
    chk("R5 andi zero-ext", ram[1], 32'h0000_8000);
    chk("R5 ori zero-ext", ram[2], 32'h0000_8001);
    chk("R5 xori zero-ext", ram[3], 32'hFFFF_7FFE);
    chk("R5 lui", ram[4], 32'h8765_0000);
    chk("R5 slti", ram[5], 32'd1);
    chk("R5 sltiu big", ram[6], 32'd1);
    chk("R5 sltiu unsigned", ram[7], 32'd0);
    chk("R1 regs cleared", ram[8], 32'd0);
    chk("R1 stack preset", ram[9], 32'h7FFF_EFFC);
  endtask

  task automatic test_mem();
    wipe(32'hDEAD_BEEF);
    poke(1'b0, 3, 32'h1357_2468);
    poke(1'b0, 5, 32'h0BAD_F00D);
    emit(ii(O_ADDIU, 0, 5, 16'h0100));
    emit(ii(O_LW, 5, 1, 16'd12));
    emit(ii(O_SW, 5, 1, 16'hFFFC));
    emit(ii(O_SW, 0, 1, 16'h002B));
    emit(ii(O_ADDIU, 0, 7, 16'h7714));
    emit(ii(O_LW, 7, 2, 16'd0));
    st(2, 0);
    emit(HALT_W);
    run(pidx, 1'b0, "mem");
    chk("R6 negative offset", ram[63], 32'h1357_2468);
    chk("R6 low bits ignored", ram[10], 32'h1357_2468);
    chk("R6 high bits ignored", ram[0], 32'h0BAD_F00D);
  endtask

  task automatic test_halt();
    wipe(32'hDEAD_BEEF);
    emit(ii(O_ADDIU, 0, 1, 16'd3));
    st(1, 0);
    emit(ri(6'd1, 0, 0, 0, 0));
    st(0, 0);
    run(3, 1'b0, "R10 bad funct");
    chk("R10 stopped", ram[0], 32'd3);
    wipe(32'hDEAD_BEEF);
    emit(ii(O_ADDIU, 0, 2, 16'd9));
    st(2, 1);
    emit(ri(F_JR, 0, 0, 0, 0));
    st(0, 1);
    run(3, 1'b0, "R10 zero pc");
    chk("R10 jump to zero", ram[1], 32'd9);
  endtask

  task automatic test_sort();
    int vals [8] = '{22, 5, -9, 3, -17, 38, 0, 11};
    int want [8] = '{-17, -9, 0, 3, 5, 11, 22, 38};
    wipe(32'd0);
    for (int i = 0; i < 8; i++) poke(1'b0, i, 32'(vals[i]));
    emit(ii(O_LW, 29, 4, 16'd0));
    emit(ii(O_ADDIU, 29, 5, 16'd4));
    emit(ii(O_ADDIU, 5, 6, 16'd4));
    emit(ri(F_SLL, 0, 4, 2, 2));
    emit(ri(F_ADDU, 6, 2, 6, 0));
    emit(jj(O_JAL, 26'h100016));
    emit(32'h0000_0000);
    emit(ii(O_ORI, 0, 2, 16'd10));
    emit(ri(6'd12, 0, 0, 0, 0));
    emit(ii(O_LUI, 0, 1, 16'h1001));          // 9: pairwise exchange routine
    emit(ii(O_ORI, 1, 8, 16'd0));
    emit(ri(F_SLL, 0, 4, 9, 2));
    emit(ri(F_ADDU, 8, 9, 9, 0));
    emit(ii(O_LW, 9, 10, 16'd0));
    emit(ri(F_SLL, 0, 5, 11, 2));
    emit(ri(F_ADDU, 8, 11, 11, 0));
    emit(ii(O_LW, 11, 12, 16'd0));
    emit(ri(F_SLT, 12, 10, 13, 0));
    emit(ii(O_BEQ, 13, 0, 16'd3));
    emit(ii(O_SW, 9, 12, 16'd0));
    emit(ii(O_SW, 11, 10, 16'd0));
    emit(ri(F_JR, 31, 0, 0, 0));
    emit(ii(O_ADDIU, 29, 29, 16'hFFF4));      // 22: outer routine
    emit(ii(O_SW, 29, 31, 16'd8));
    emit(ii(O_SW, 29, 17, 16'd4));
    emit(ii(O_SW, 29, 16, 16'd0));
    emit(ii(O_ADDIU, 0, 16, 16'd0));
    emit(ii(O_SLTI, 16, 8, 16'd8));
    emit(ii(O_BEQ, 8, 0, 16'd11));
    emit(ii(O_ADDIU, 16, 17, 16'd1));
    emit(ii(O_SLTI, 17, 8, 16'd8));
    emit(ii(O_BEQ, 8, 0, 16'd6));
    emit(ii(O_ADDIU, 16, 4, 16'd0));
    emit(ii(O_ADDIU, 17, 5, 16'd0));
    emit(jj(O_JAL, 26'h100009));
    emit(ii(O_ADDIU, 17, 17, 16'd1));
    emit(jj(O_J, 26'h10001E));
    emit(ii(O_ADDIU, 16, 16, 16'd1));
    emit(jj(O_J, 26'h10001B));
    emit(ii(O_LW, 29, 31, 16'd8));
    emit(ii(O_LW, 29, 17, 16'd4));
    emit(ii(O_LW, 29, 16, 16'd0));
    emit(ii(O_ADDIU, 29, 29, 16'd12));
    emit(ri(F_JR, 31, 0, 0, 0));
    run(611, 1'b0, "R13 sort");
    for (int i = 0; i < 8; i++) chk("R13 sorted word", ram[i], 32'(want[i]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2: watchdog expired, got done=%0d expected 1", done);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    test_alu();
    test_flow();
    test_imm();
    test_mem();
    test_halt();
    test_sort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule